// File: doc/BRIEF.md
# Framing Bit Out-of-Frame Detector

This block sits on a T1 receive path after the framing-bit comparator. On each framing bit it gets a strobe and a flag that says whether that bit failed its check. The checked bits are the terminal framing bits in superframe mode, or the framing pattern sequence bits in extended superframe mode. The block keeps a short history of these results. It raises a one-cycle out-of-frame pulse when two errors fall inside a sliding window of the newest 4, 5 or 6 framing bits.

Two control bits choose the window length. The long-window bit takes priority over the mid-window bit. The history is cleared in four cases: when an event fires, when the in-sync qualifier is low, when either control bit changes, and on reset. This way one burst of errors produces exactly one event, and no decision mixes two window lengths. Bit extraction, pattern comparison and alignment search are done by neighbouring blocks.

Top module: `oof_detector`

## Requirements
- R1: With `win_mid` = 0 and `win_long` = 0, an event fires when 2 or more of the newest 4 framing-bit results, including the one just strobed, are errors.
- R2: With `win_mid` = 1 and `win_long` = 0, the window is the newest 5 framing-bit results.
- R3: With `win_long` = 1, the window is the newest 6 framing-bit results, whatever `win_mid` holds.
- R4: The history advances only in a cycle where `fb_strobe` = 1. In cycles without a strobe, `fb_err` is ignored and `oof_pulse` stays 0.
- R5: `oof_pulse` is high for exactly one cycle. It rises in the cycle after the clock edge that sampled the deciding strobe. The history is empty after the event, so a single further error cannot fire again.
- R6: While `in_sync` = 0, `oof_pulse` stays 0 and the history is held empty. Any strobe in such a cycle is discarded.
- R7: In a cycle where `win_mid` or `win_long` differs from its value in the previous cycle, the history is emptied and any strobe in that cycle is discarded.
- R8: After synchronous reset (`rst` = 1), `oof_pulse` is 0 and the history is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fb_strobe | input | 1 | One cycle per checked framing bit |
| fb_err | input | 1 | Framing bit failed its check, valid with fb_strobe |
| win_mid | input | 1 | Selects the 5-bit window |
| win_long | input | 1 | Selects the 6-bit window, overrides win_mid |
| in_sync | input | 1 | Detection enabled while high |
| oof_pulse | output | 1 | Out-of-frame event, one cycle |

## Verification
The history is not visible at the ports. A wrong entry only shows through the timing of `oof_pulse`, which then appears at a strobe where it should not, or goes missing where it should appear. A stale entry left behind by a clear, a sync drop or a control-bit change shows up at the first strobe that pairs it with a fresh error. A wrong window length shows up at the first error pair spaced exactly at the window boundary. The bench therefore probes pairs spaced 3, 4 and 5 strobes apart under each setting, and places single errors right after each kind of clear.

// File: rtl/oof_pkg.sv
package oof_pkg;

    localparam int HIST_MAX  = 6;
    localparam int WIN_SHORT_LEN = 4;
    localparam int WIN_MID_LEN   = 5;
    localparam int WIN_LONG_LEN  = 6;
    localparam int ERR_LIMIT = 2;
    localparam int CNT_W     = $clog2(HIST_MAX + 1);

    typedef logic [HIST_MAX-1:0] hist_t;
    typedef logic [CNT_W-1:0]    cnt_t;

    typedef enum logic [1:0] {
        WSEL_SHORT  = 2'd0,
        WSEL_MEDIUM = 2'd1,
        WSEL_WIDE   = 2'd2
    } win_e;

    typedef struct packed {
        logic sel_long;
        logic sel_mid;
    } win_ctl_t;

    function automatic win_e decode_win(win_ctl_t c);
        if (c.sel_long)     return WSEL_WIDE;
        else if (c.sel_mid) return WSEL_MEDIUM;
        else                return WSEL_SHORT;
    endfunction

    function automatic cnt_t win_len(win_e w);
        case (w)
            WSEL_WIDE:   return cnt_t'(WIN_LONG_LEN);
            WSEL_MEDIUM: return cnt_t'(WIN_MID_LEN);
            default:     return cnt_t'(WIN_SHORT_LEN);
        endcase
    endfunction

    function automatic hist_t win_mask(cnt_t n);
        hist_t m;
        for (int i = 0; i < HIST_MAX; i++) begin
            m[i] = (cnt_t'(i) < n);
        end
        return m;
    endfunction

    function automatic cnt_t count_ones(hist_t v);
        cnt_t c;
        c = '0;
        for (int i = 0; i < HIST_MAX; i++) begin
            c = c + cnt_t'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/oof_win_ctl.sv
module oof_win_ctl
    import oof_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  win_ctl_t ctl,
    output win_e     win,
    output logic     changed
);

    win_ctl_t ctl_q;

    always_ff @(posedge clk) begin
        ctl_q <= ctl;
    end

    assign changed = !rst && (ctl != ctl_q);
    assign win     = decode_win(ctl);

    p_wide_dominates_r3: assert property (@(posedge clk) disable iff (rst)
        ctl.sel_long |-> (win_len(win) == cnt_t'(WIN_LONG_LEN)));

endmodule

// File: rtl/oof_win_eval.sv
module oof_win_eval
    import oof_pkg::*;
(
    input  hist_t hist,
    input  logic  err_in,
    input  win_e  win,
    output hist_t cand,
    output logic  trip
);

    cnt_t  n_err;
    hist_t masked;

    always_comb begin
        cand   = {hist[HIST_MAX-2:0], err_in};
        masked = cand & win_mask(win_len(win));
        n_err  = count_ones(masked);
        trip   = (n_err >= cnt_t'(ERR_LIMIT));
    end

endmodule

// File: rtl/oof_err_hist.sv
module oof_err_hist
    import oof_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  load,
    input  hist_t load_val,
    output hist_t hist
);

    always_ff @(posedge clk) begin
        if (rst || clr)  hist <= '0;
        else if (load)   hist <= load_val;
    end

    p_hold_between_strobes_r4: assert property (@(posedge clk) disable iff (rst)
        (!load && !clr) |=> $stable(hist));

    p_clear_empties_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (hist == '0));

endmodule

// File: rtl/oof_detector.sv
module oof_detector
    import oof_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fb_strobe,
    input  logic fb_err,
    input  logic win_mid,
    input  logic win_long,
    input  logic in_sync,
    output logic oof_pulse
);

    win_ctl_t ctl;
    win_e     win;
    logic     ctl_changed;
    hist_t    hist;
    hist_t    cand;
    logic     trip;
    logic     accept;
    logic     fire;
    logic     hist_clr;

    assign ctl.sel_mid  = win_mid;
    assign ctl.sel_long = win_long;

    oof_win_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .win     (win),
        .changed (ctl_changed)
    );

    oof_win_eval u_eval (
        .hist   (hist),
        .err_in (fb_err),
        .win    (win),
        .cand   (cand),
        .trip   (trip)
    );

    assign accept   = fb_strobe && in_sync && !ctl_changed;
    assign fire     = accept && trip;
    assign hist_clr = !in_sync || ctl_changed || fire;

    oof_err_hist u_hist (
        .clk      (clk),
        .rst      (rst),
        .clr      (hist_clr),
        .load     (accept),
        .load_val (cand),
        .hist     (hist)
    );

    always_ff @(posedge clk) begin
        if (rst) oof_pulse <= 1'b0;
        else     oof_pulse <= fire;
    end

    p_pulse_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        oof_pulse |-> $past(fb_strobe));

    p_single_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        oof_pulse |=> !oof_pulse);

    p_quiet_out_of_sync_r6: assert property (@(posedge clk) disable iff (rst)
        !in_sync |=> !oof_pulse);

    p_quiet_on_sel_change_r7: assert property (@(posedge clk) disable iff (rst)
        ((win_mid != $past(win_mid)) || (win_long != $past(win_long))) |=> !oof_pulse);

    p_reset_quiet_r8: assert property (@(posedge clk)
        $past(rst) |-> !oof_pulse);

endmodule

// File: tb/sim_oof_detector.sv
module sim_oof_detector;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic clk = 1'b0;
    logic rst, fb_strobe, fb_err, win_mid, win_long, in_sync;
    logic oof_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    logic [5:0] m_hist;
    logic [1:0] m_prev;
    logic       m_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    oof_detector u0 (
        .clk(clk), .rst(rst), .fb_strobe(fb_strobe), .fb_err(fb_err),
        .win_mid(win_mid), .win_long(win_long), .in_sync(in_sync),
        .oof_pulse(oof_pulse)
    );

    function automatic int wlen(logic a, logic b);
        return b ? 6 : (a ? 5 : 4);
    endfunction

    function automatic int ones_in(logic [5:0] h, int n);
        int c = 0;
        for (int i = 0; i < n; i++) c += h[i];
        return c;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: oof_pulse=%0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(logic s, logic e, logic a, logic b, logic y, string tag);
        logic [5:0] h;
        fb_strobe = s; fb_err = e; win_mid = a; win_long = b; in_sync = y;
        @(posedge clk);
        #1;
        if (!y || {a, b} != m_prev) begin
            m_hist = '0; m_exp = 1'b0;
        end else if (s) begin
            h = {m_hist[4:0], e};
            if (ones_in(h, wlen(a, b)) >= 2) begin
                m_exp = 1'b1; m_hist = '0;
            end else begin
                m_exp = 1'b0; m_hist = h;
            end
        end else begin
            m_exp = 1'b0;
        end
        m_prev = {a, b};
        check(tag, oof_pulse, m_exp);
    endtask

    task automatic do_reset(logic a, logic b);
        rst = 1'b1; fb_strobe = 0; fb_err = 0; win_mid = a; win_long = b; in_sync = 1;
        repeat (2) @(posedge clk);
        #1;
        check("R8", oof_pulse, 1'b0);
        rst = 1'b0;
        m_hist = '0; m_prev = {a, b}; m_exp = 1'b0;
    endtask

    task automatic pair(logic a, logic b, int gap, string tag);
        step(1, 1, a, b, 1, tag);
        for (int i = 0; i < gap - 1; i++) begin
            step(1, 0, a, b, 1, tag);
            step(0, 1, a, b, 1, "R4");
        end
        step(1, 1, a, b, 1, tag);
        step(0, 0, a, b, 1, "R5");
        for (int i = 0; i < 7; i++) step(1, 0, a, b, 1, tag);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1723));
        do_reset(0, 0);
        for (int g = 1; g <= 5; g++) pair(0, 0, g, "R1");
        do_reset(1, 0);
        for (int g = 1; g <= 5; g++) pair(1, 0, g, "R2");
        do_reset(0, 1);
        for (int g = 1; g <= 6; g++) pair(0, 1, g, "R3");
        for (int g = 4; g <= 6; g++) pair(1, 1, g, "R3");
        step(1, 1, 1, 1, 1, "R5");
        step(1, 1, 1, 1, 1, "R5");
        step(0, 0, 1, 1, 1, "R5");
        step(1, 1, 1, 1, 1, "R5");
        step(1, 0, 1, 1, 1, "R5");
        step(1, 1, 1, 1, 1, "R5");
        step(1, 0, 1, 1, 1, "R6");
        step(1, 1, 1, 1, 0, "R6");
        step(1, 1, 1, 1, 1, "R6");
        step(1, 1, 1, 1, 1, "R6");
        step(1, 1, 0, 1, 1, "R7");
        step(1, 1, 1, 1, 1, "R7");
        step(1, 1, 1, 1, 1, "R7");
        step(1, 1, 1, 1, 1, "R7");
        step(1, 1, 1, 1, 1, "R7");
        step(1, 1, 1, 1, 1, "R7");
        for (int i = 0; i < 4000; i++) begin
            logic s, e, a, b, y;
            string tag;
            s = ($urandom % 3) == 0;
            e = ($urandom % 4) == 0;
            a = m_prev[1]; b = m_prev[0];
            if (($urandom % 60) == 0) a = ~a;
            if (($urandom % 60) == 0) b = ~b;
            y = ($urandom % 40) != 0;
            if (!y)                  tag = "R6";
            else if ({a, b} != m_prev) tag = "R7";
            else if (!s)             tag = "R4";
            else if (b)              tag = "R3";
            else if (a)              tag = "R2";
            else                     tag = "R1";
            step(s, e, a, b, y, tag);
        end
        do_reset(0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule